// File: doc/BRIEF.md
# Shared Bus Arbiter with Host Preemption

This block decides which master owns a shared parallel bus. Four slot masters ask for the bus on active-low request lines and get an active-low grant each. A fifth master is the host bridge, which carries CPU-side accesses. The bridge cannot stall, so it always wins. The arbiter takes the bus away from any slot master the moment the host asks. It then watches the transfer handshake lines and holds back the host grant until the preempted master's data phase has completed or the bus has gone idle.

Slot masters share the bus in turns of a fixed number of clocks, and the next master is picked round-robin. A turn ends early when its master drops its request, or when the master never starts a transfer within a timeout. If the host cuts a turn short, the master keeps the clocks it has not used. It gets the bus back first when the host is done, even if other masters are waiting. At least one clock with no grant separates any two owners.

Top module: `busarb_preempt`

## Requirements
- R1: At most one grant is active at any time. The host grant counts, along with the four slot grants (an active slot grant is a 0 on `mgnt_n[i]`).
- R2: When `host_req` is high in a clock where a slot grant is active, every slot grant is deasserted in the next clock.
- R3: `host_gnt` rises only after a clock in which the arbiter held no grant and saw either `tgt_rdy_n` low or both `txn_n` and `init_rdy_n` high. It therefore comes no earlier than two clocks after `host_req` is first seen.
- R4: A slot master that holds its grant for TIMEOUT clocks without ever driving `txn_n` low loses its grant.
- R5: A slot master keeps its grant for at most BUDGET clocks per turn while another slot master is requesting. If no other master is requesting, it starts a fresh turn and keeps the grant.
- R6: A slot master preempted before its turn is used up gets the grant back first after `host_req` falls, regardless of other requests, and keeps it for the rest of that turn.
- R7: If the granted slot master raises its `mreq_n` bit while `host_req` is low, its grant is removed in the next clock and the rest of its turn is dropped.
- R8: With no requests, every grant stays deasserted. The next grant then gets a full BUDGET-clock turn.
- R9: The next slot grant goes round-robin to the first requester after the master that last ended its turn, in increasing index order with wrap-around. After reset the search starts at master 0.
- R10: A grant never becomes active in the same clock that another one goes inactive. Between two different owners there is at least one clock with no grant.
- R11: `host_gnt` stays high while `host_req` is high and falls in the clock after `host_req` is seen low.
- R12: During reset (`rst_n` low) every `mgnt_n` bit is 1 and `host_gnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mreq_n | input | NM | Slot master requests, active low |
| mgnt_n | output | NM | Slot master grants, active low |
| txn_n | input | 1 | Transfer-in-progress (cycle frame) line, active low |
| init_rdy_n | input | 1 | Initiator ready, active low |
| tgt_rdy_n | input | 1 | Target ready, active low; low marks a completed data phase |
| host_req | input | 1 | Host bridge request, active high |
| host_gnt | output | 1 | Host bridge grant, active high |

## Verification
Every output comes from a register, so each decision shows on the pins one clock after the inputs that caused it are sampled. A request seen in an idle clock gives a grant one clock later. A host request gives a slot-grant drop one clock later, and the host grant follows no sooner than the clock after the drain condition is seen. The bench changes inputs one time unit after each rising edge. At that same point it steps a behavioural model with the values just sampled and compares every output. The compare therefore always uses the state the design reached at that edge.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SLOT  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_HOST  = 2'd3
  } arb_state_t;
endpackage

// File: rtl/busarb_rr_pick.sv
module busarb_rr_pick #(
  parameter int NM = 4,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic [NM-1:0] req,
  input  logic [IW-1:0] last,
  output logic          hit,
  output logic [IW-1:0] pick
);
  // search starts one past the last finisher, wrapping around
  always_comb begin
    int idx;
    hit  = 1'b0;
    pick = last;
    for (int k = 1; k <= NM; k++) begin
      idx = (int'(last) + k) % NM;
      if (!hit && req[idx]) begin
        hit  = 1'b1;
        pick = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/busarb_turn_timer.sv
module busarb_turn_timer #(
  parameter int BUDGET  = 16,
  parameter int TIMEOUT = 16,
  localparam int UW = $clog2(BUDGET + 1),
  localparam int TW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [UW-1:0] load_used,
  input  logic          run,
  input  logic          wrap,
  input  logic          txn_n,
  output logic [UW-1:0] used,
  output logic          last_cycle,
  output logic          expired
);
  logic [TW-1:0] idle_cnt;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used     <= '0;
      idle_cnt <= '0;
      seen     <= 1'b0;
    end else if (load) begin
      used     <= load_used;
      idle_cnt <= '0;
      seen     <= 1'b0;
    end else if (run) begin
      used <= wrap ? '0 : used + 1'b1;
      if (!txn_n) seen <= 1'b1;
      if (idle_cnt != TW'(TIMEOUT - 1)) idle_cnt <= idle_cnt + 1'b1;
    end else begin
      used     <= '0;
      idle_cnt <= '0;
      seen     <= 1'b0;
    end
  end

  assign last_cycle = (used == UW'(BUDGET - 1));
  assign expired    = run && !seen && txn_n && (idle_cnt == TW'(TIMEOUT - 1));

  // R8: with no turn running or starting, the budget count returns to rest
  a_r8_count_rests: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> (used == '0));
endmodule

// File: rtl/busarb_preempt.sv
module busarb_preempt #(
  parameter int NM      = 4,
  parameter int BUDGET  = 16,
  parameter int TIMEOUT = 16,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1,
  localparam int UW = $clog2(BUDGET + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] mreq_n,
  output logic [NM-1:0] mgnt_n,
  input  logic          txn_n,
  input  logic          init_rdy_n,
  input  logic          tgt_rdy_n,
  input  logic          host_req,
  output logic          host_gnt
);
  import busarb_pkg::*;

  arb_state_t    state;
  logic [IW-1:0] owner;
  logic [IW-1:0] rr_last;
  logic          res_v;
  logic [IW-1:0] res_own;
  logic [UW-1:0] res_used;

  logic [NM-1:0] req;
  logic          rr_hit;
  logic [IW-1:0] rr_pick;
  logic          own_req, others, drain_done;
  logic          t_load, t_run, t_wrap;
  logic [UW-1:0] t_load_used, t_used;
  logic          t_last, t_expired;
  logic [IW-1:0] sel;

  assign req        = ~mreq_n;
  assign own_req    = req[owner];
  assign others     = |(req & ~(NM'(1) << owner));
  assign drain_done = !tgt_rdy_n || (txn_n && init_rdy_n);

  busarb_rr_pick #(.NM(NM)) u_pick (
    .req  (req),
    .last (rr_last),
    .hit  (rr_hit),
    .pick (rr_pick)
  );

  // start-of-turn selection: a resumed master beats round-robin
  always_comb begin
    t_load      = 1'b0;
    t_load_used = '0;
    sel         = rr_pick;
    if (state == ST_IDLE && !host_req) begin
      if (res_v && req[res_own]) begin
        t_load      = 1'b1;
        t_load_used = res_used;
        sel         = res_own;
      end else if (rr_hit) begin
        t_load = 1'b1;
      end
    end
  end

  assign t_run  = (state == ST_SLOT);
  assign t_wrap = t_run && t_last && !others && own_req && !host_req;

  busarb_turn_timer #(.BUDGET(BUDGET), .TIMEOUT(TIMEOUT)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (t_load),
    .load_used  (t_load_used),
    .run        (t_run),
    .wrap       (t_wrap),
    .txn_n      (txn_n),
    .used       (t_used),
    .last_cycle (t_last),
    .expired    (t_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      owner    <= '0;
      rr_last  <= IW'(NM - 1);
      res_v    <= 1'b0;
      res_own  <= '0;
      res_used <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (host_req) begin
            state <= ST_DRAIN;
          end else begin
            res_v <= 1'b0;
            if (t_load) begin
              state <= ST_SLOT;
              owner <= sel;
            end
          end
        end
        ST_SLOT: begin
          if (host_req) begin
            state <= ST_DRAIN;
            if (!t_last) begin
              res_v    <= 1'b1;
              res_own  <= owner;
              res_used <= t_used + 1'b1;
            end
          end else if (!own_req || (t_last && others) || t_expired) begin
            state   <= ST_IDLE;
            rr_last <= owner;
          end
        end
        ST_DRAIN: begin
          if (!host_req)       state <= ST_IDLE;
          else if (drain_done) state <= ST_HOST;
        end
        default: begin
          if (!host_req) state <= ST_IDLE;
        end
      endcase
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NM; gi++) begin : g_gnt
      assign mgnt_n[gi] = !(state == ST_SLOT && owner == IW'(gi));

      // R7: a withdrawn request costs the grant one clock later
      a_r7_forfeit: assert property (@(posedge clk) disable iff (!rst_n)
        (!mgnt_n[gi] && mreq_n[gi] && !host_req) |=> mgnt_n[gi]);

      // R10: a slot grant only starts after a clock with no owner
      a_r10_gap_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mgnt_n[gi]) |-> ($past(mgnt_n) == '1 && !$past(host_gnt)));
    end
  endgenerate

  assign host_gnt = (state == ST_HOST);

  a_r1_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~mgnt_n, host_gnt}) <= 1);

  a_r2_quick_release: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && mgnt_n != '1) |=> (mgnt_n == '1));

  a_r3_drain_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_gnt) |-> $past(!tgt_rdy_n || (txn_n && init_rdy_n)));

  a_r10_gap_host: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_gnt) |-> ($past(mgnt_n) == '1));

  a_r11_host_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (host_gnt && !host_req) |=> !host_gnt);
endmodule

// File: tb/test_busarb_preempt.sv
module test_busarb_preempt;
  localparam int NM  = 4;
  localparam int BUD = 16;
  localparam int TMO = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NM-1:0] mreq_n = '1;
  logic [NM-1:0] mgnt_n;
  logic          txn_n = 1'b1, init_rdy_n = 1'b1, tgt_rdy_n = 1'b1;
  logic          host_req = 1'b0;
  logic          host_gnt;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R12";
  bit auto_bus = 1'b0;

  // reference model state
  int m_mode = 0, m_own = 0, m_used = 0, m_idle = 0, m_rr = NM - 1;
  bit m_seen = 0, m_rv = 0;
  int m_rown = 0, m_rused = 0;
  logic [NM-1:0] prev_gnt = '1;
  bit prev_host = 0;

  always #5 clk = ~clk;

  busarb_preempt #(.NM(NM), .BUDGET(BUD), .TIMEOUT(TMO)) i_busarb_preempt (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .mgnt_n(mgnt_n),
    .txn_n(txn_n), .init_rdy_n(init_rdy_n), .tgt_rdy_n(tgt_rdy_n),
    .host_req(host_req), .host_gnt(host_gnt)
  );

  task automatic start_turn(input int who, input int u);
    m_mode = 1; m_own = who; m_used = u; m_idle = 0; m_seen = 0;
  endtask

  task automatic model_step();
    logic [NM-1:0] rq;
    bit others, last, expd, found;
    rq = ~mreq_n;
    if (!rst_n) begin
      m_mode = 0; m_own = 0; m_used = 0; m_idle = 0; m_rr = NM - 1;
      m_seen = 0; m_rv = 0;
      return;
    end
    case (m_mode)
      0: begin
        if (host_req) m_mode = 2;
        else begin
          if (m_rv && rq[m_rown]) start_turn(m_rown, m_rused);
          else begin
            found = 0;
            for (int k = 1; k <= NM; k++)
              if (!found && rq[(m_rr + k) % NM]) begin
                found = 1; start_turn((m_rr + k) % NM, 0);
              end
          end
          m_rv = 0;
        end
      end
      1: begin
        others = 0;
        for (int j = 0; j < NM; j++) if (j != m_own && rq[j]) others = 1;
        last = (m_used == BUD - 1);
        expd = !m_seen && txn_n && (m_idle == TMO - 1);
        if (host_req) begin
          m_mode = 2;
          if (!last) begin m_rv = 1; m_rown = m_own; m_rused = m_used + 1; end
        end else if (!rq[m_own] || (last && others) || expd) begin
          m_mode = 0; m_rr = m_own;
        end else begin
          m_used = last ? 0 : m_used + 1;
          if (!txn_n) m_seen = 1;
          if (m_idle != TMO - 1) m_idle++;
        end
      end
      2: begin
        if (!host_req) m_mode = 0;
        else if (!tgt_rdy_n || (txn_n && init_rdy_n)) m_mode = 3;
      end
      default: if (!host_req) m_mode = 0;
    endcase
  endtask

  task automatic compare();
    logic [NM-1:0] eg;
    bit eh;
    eg = (m_mode == 1) ? ~(NM'(1) << m_own) : '1;
    eh = (m_mode == 3);
    checks++;
    if (mgnt_n !== eg || host_gnt !== eh) begin
      errors++;
      $display("FAIL %s cyc %0d: gnt_n=%b host=%b expected gnt_n=%b host=%b",
               tag, cyc, mgnt_n, host_gnt, eg, eh);
    end
    // R1: single owner
    checks++;
    if ($countones({~mgnt_n, host_gnt}) > 1) begin
      errors++;
      $display("FAIL R1 cyc %0d: owners=%b expected at most one", cyc, {~mgnt_n, host_gnt});
    end
    // R10: a new owner follows an idle clock
    checks++;
    if (((mgnt_n != '1 && mgnt_n != prev_gnt) || (host_gnt && !prev_host)) &&
        (prev_gnt != '1 || prev_host)) begin
      errors++;
      $display("FAIL R10 cyc %0d: gnt_n=%b host=%b after gnt_n=%b host=%b expected idle gap",
               cyc, mgnt_n, host_gnt, prev_gnt, prev_host);
    end
    prev_gnt = mgnt_n;
    prev_host = host_gnt;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      cyc++;
      model_step();
      compare();
      if (auto_bus) begin
        txn_n      = (mgnt_n == '1);
        init_rdy_n = (mgnt_n == '1);
        tgt_rdy_n  = (mgnt_n == '1);
      end
    end
  endtask

  initial begin
    // R12: reset state
    step(3);
    rst_n = 1'b1;

    // R7 and R9: lone master 2, then it withdraws
    tag = "R9"; auto_bus = 1; mreq_n = 4'b1011;
    step(8);
    tag = "R7"; mreq_n = 4'b1111;
    step(4);

    // R5 and R9: three masters contend for the budget
    tag = "R5"; mreq_n = 4'b0100;
    step(90);
    tag = "R5"; mreq_n = 4'b1101;   // master 1 alone keeps the bus
    step(40);
    mreq_n = '1;
    step(3);

    // R4: master 3 granted but never starts a transfer
    tag = "R4"; auto_bus = 0; txn_n = 1; init_rdy_n = 1; tgt_rdy_n = 1;
    mreq_n = 4'b0111; step(20);
    mreq_n = 4'b0110; step(40);
    mreq_n = '1; step(3);

    // R2, R3, R6: host preempts master 0 mid-transfer
    tag = "R2"; auto_bus = 1; mreq_n = 4'b1110;
    step(6);
    mreq_n = 4'b1100;
    auto_bus = 0; txn_n = 0; init_rdy_n = 0; tgt_rdy_n = 1;
    host_req = 1;
    step(1);
    tag = "R3"; step(4);
    tgt_rdy_n = 0; step(1);
    txn_n = 1; init_rdy_n = 1; tgt_rdy_n = 1;
    step(5);
    tag = "R6"; host_req = 0; auto_bus = 1;
    step(40);
    mreq_n = '1; step(3);

    // R11: host alone
    tag = "R11"; host_req = 1; step(6);
    host_req = 0; step(3);

    // R8: quiet bus, then fresh full turns
    tag = "R8"; step(20);
    mreq_n = 4'b1001; step(50);
    mreq_n = '1; step(5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule